// File: doc/BRIEF.md
# DDR Mode Register Programming Sequencer

This block sits in a DDR SDRAM controller. It writes the two mode registers of the memory from a single configuration request. On a start strobe it captures the requested burst length code, burst type, CAS latency code, DLL-reset flag and a full extended-register value. It then checks the two codes for reserved values. If both are legal, it waits until the memory reports all banks idle with CKE high, and issues the extended-register write followed by the base-register write. Each command occupies a single clock cycle with all four command strobes low.

A fixed number of NOP cycles (`GAP_CYC`, default 2) separates the two writes, and the same number follows the last write before the block signals completion. If either code is reserved, the request is refused with a one-cycle error pulse, and nothing is driven on the command pins. Power-up timing, refresh, precharge and data traffic belong to other blocks.

Top module: `ddr_mode_prog`

## Requirements
- R1: After reset, and whenever no write command is being issued, the pins rest at NOP: `cs_n_o`, `ras_n_o`, `cas_n_o` and `we_n_o` all 1, with `ba_o` and `addr_o` zero. `busy_o`, `done_o` and `cfg_err_o` are 0 after reset.
- R2: The inputs `bl_code_i`, `bt_i`, `cl_code_i`, `dll_rst_i` and `ext_val_i` are captured on the edge that accepts `start_i`. Later changes to them have no effect on the running sequence.
- R3: The extended-register write is issued first. In that cycle all four strobes are 0, `ba_o` = 1 and `addr_o` = the captured `ext_val_i`. With the memory ready, it appears on the second edge after the accepting edge.
- R4: In the base-register write all four strobes are 0 and `ba_o` = 0. `addr_o` carries burst length on bits 2..0, burst type on bit 3 (0 sequential, 1 interleave), CAS latency on bits 6..4 and DLL reset on bit 8. Bit 7 (test mode) and bits 10..9 are 0.
- R5: Each write lasts exactly one cycle. At least `GAP_CYC` NOP cycles lie between the two writes, and exactly `GAP_CYC` when the memory stays ready.
- R6: No write is issued in a cycle unless `banks_idle_i` and `cke_i` were both 1 on the edge that launched it. While either is low, the sequence holds before the pending write.
- R7: Burst length codes 001, 010 and 011 are legal. Any other code makes `cfg_err_o` pulse for one cycle on the edge after the accepting edge, with no write issued and no done pulse.
- R8: CAS latency codes 010, 011 and 110 are legal. Any other code is refused in the same way as in R7.
- R9: `done_o` is high for exactly one cycle, `GAP_CYC` + 1 cycles after the base-register write.
- R10: `busy_o` is high from the cycle after acceptance through the done cycle, or through the cycle before the error pulse. A `start_i` seen while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to program both mode registers |
| bl_code_i | input | 3 | Burst length code |
| bt_i | input | 1 | Burst type, 1 = interleave |
| cl_code_i | input | 3 | CAS latency code |
| dll_rst_i | input | 1 | DLL reset request bit |
| ext_val_i | input | ADDR_W | Value written to the extended register |
| banks_idle_i | input | 1 | All banks precharged and idle |
| cke_i | input | 1 | Current CKE level |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | RAS strobe, active low |
| cas_n_o | output | 1 | CAS strobe, active low |
| we_n_o | output | 1 | WE strobe, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bits A0 upward |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle reserved-code pulse |

## Verification
The hardest case to reach from the ports is the memory losing readiness after the extended write has gone out but before the base write. The block must then stretch the gap rather than issue the second write into a busy memory. The stimulus drops either `banks_idle_i` or `cke_i` at a chosen cycle inside the gap window and raises it again a few cycles later. The bench predicts the delayed write cycle from that schedule. Random runs vary the pre-start hold-off, the codes (legal and reserved), restarts while busy and input changes after acceptance.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_EMRS,
    ST_WAIT_E,
    ST_MRS,
    ST_WAIT_M,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       bt;
    logic [2:0] cl;
    logic       dll;
  } mode_cfg_t;

  localparam logic [2:0] BL_2   = 3'b001;
  localparam logic [2:0] BL_4   = 3'b010;
  localparam logic [2:0] BL_8   = 3'b011;
  localparam logic [2:0] CL_2   = 3'b010;
  localparam logic [2:0] CL_3   = 3'b011;
  localparam logic [2:0] CL_2P5 = 3'b110;

  function automatic logic bl_legal(input logic [2:0] code);
    return (code == BL_2) || (code == BL_4) || (code == BL_8);
  endfunction

  function automatic logic cl_legal(input logic [2:0] code);
    return (code == CL_2) || (code == CL_3) || (code == CL_2P5);
  endfunction

endpackage

// File: rtl/ddr_mode_cfg_chk.sv
module ddr_mode_cfg_chk
  import ddr_mode_pkg::*;
(
  input  mode_cfg_t cfg_i,
  output logic      bl_ok_o,
  output logic      cl_ok_o,
  output logic      ok_o
);
  assign bl_ok_o = bl_legal(cfg_i.bl);
  assign cl_ok_o = cl_legal(cfg_i.cl);
  assign ok_o    = bl_ok_o & cl_ok_o;
endmodule

// File: rtl/ddr_mode_gap_cnt.sv
module ddr_mode_gap_cnt #(
  parameter int unsigned GAP_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic zero_o
);
  localparam int unsigned CNT_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_V;
    end else if (en_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_mode_cmd_enc.sv
module ddr_mode_cmd_enc
  import ddr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned BA_W   = 2
) (
  input  state_e            state_i,
  input  mode_cfg_t         cfg_i,
  input  logic [ADDR_W-1:0] ext_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_addr;
  logic              issue;

  always_comb begin
    base_addr      = '0;
    base_addr[2:0] = cfg_i.bl;
    base_addr[3]   = cfg_i.bt;
    base_addr[6:4] = cfg_i.cl;
    base_addr[7]   = 1'b0;  // test mode stays off
    base_addr[8]   = cfg_i.dll;
  end

  assign issue = (state_i == ST_EMRS) || (state_i == ST_MRS);

  always_comb begin
    cs_n_o  = ~issue;
    ras_n_o = ~issue;
    cas_n_o = ~issue;
    we_n_o  = ~issue;
    ba_o    = '0;
    addr_o  = '0;
    if (state_i == ST_EMRS) begin
      ba_o   = BA_W'(1);
      addr_o = ext_i;
    end else if (state_i == ST_MRS) begin
      addr_o = base_addr;
    end
  end
endmodule

// File: rtl/ddr_mode_prog.sv
module ddr_mode_prog
  import ddr_mode_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        bl_code_i,
  input  logic              bt_i,
  input  logic [2:0]        cl_code_i,
  input  logic              dll_rst_i,
  input  logic [ADDR_W-1:0] ext_val_i,
  input  logic              banks_idle_i,
  input  logic              cke_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  state_e            state_q, state_d;
  mode_cfg_t         cfg_q;
  logic [ADDR_W-1:0] ext_q;
  logic              err_q, err_d;
  logic              cfg_ok, bl_ok, cl_ok;
  logic              mem_ready, gap_zero, gap_load, gap_en, accept;

  assign mem_ready = banks_idle_i & cke_i;
  assign accept    = (state_q == ST_IDLE) & start_i;

  ddr_mode_cfg_chk u_cfg_chk (
    .cfg_i   (cfg_q),
    .bl_ok_o (bl_ok),
    .cl_ok_o (cl_ok),
    .ok_o    (cfg_ok)
  );

  assign gap_load = (state_q == ST_EMRS) || (state_q == ST_MRS);
  assign gap_en   = (state_q == ST_WAIT_E) || (state_q == ST_WAIT_M);

  ddr_mode_gap_cnt #(.GAP_CYC(GAP_CYC)) u_gap_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (gap_load),
    .en_i   (gap_en),
    .zero_o (gap_zero)
  );

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (!(bl_ok && cl_ok)) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
        end else if (cfg_ok && mem_ready) begin
          state_d = ST_EMRS;
        end
      end
      ST_EMRS:   state_d = ST_WAIT_E;
      ST_WAIT_E: if (gap_zero && mem_ready) state_d = ST_MRS;
      ST_MRS:    state_d = ST_WAIT_M;
      ST_WAIT_M: if (gap_zero) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      cfg_q   <= '0;
      ext_q   <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (accept) begin
        cfg_q <= '{bl: bl_code_i, bt: bt_i, cl: cl_code_i, dll: dll_rst_i};
        ext_q <= ext_val_i;
      end
    end
  end

  ddr_mode_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd_enc (
    .state_i (state_q),
    .cfg_i   (cfg_q),
    .ext_i   (ext_q),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o)
  );

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign cfg_err_o = err_q;
endmodule

// File: rtl/ddr_mode_prog_chk.sv
module ddr_mode_prog_chk #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned BA_W    = 2,
  parameter int unsigned GAP_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              banks_idle_i,
  input logic              cke_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              cfg_err_o
);
  localparam int unsigned SW = $clog2(GAP_CYC + 2);
  localparam logic [SW-1:0] S_MAX = SW'(GAP_CYC + 1);
  localparam logic [ADDR_W-1:0] MRS_ZERO_MASK = ~ADDR_W'(9'h17f);

  logic          cmd_w;
  logic [SW-1:0] since_q;
  logic          emrs_seen_q;

  assign cmd_w = ~cs_n_o & ~ras_n_o & ~cas_n_o & ~we_n_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q     <= S_MAX;
      emrs_seen_q <= 1'b0;
    end else begin
      if (cmd_w) since_q <= '0;
      else if (since_q != S_MAX) since_q <= since_q + 1'b1;
      if (!busy_o) emrs_seen_q <= 1'b0;
      else if (cmd_w && ba_o == BA_W'(1)) emrs_seen_q <= 1'b1;
    end
  end

  a_r1_nop_outside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_n_o && ras_n_o && cas_n_o && we_n_o));

  a_r3_emrs_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w && ba_o == '0) |-> emrs_seen_q);

  a_r4_mrs_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w && ba_o == '0) |-> ((addr_o & MRS_ZERO_MASK) == '0));

  a_r5_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_w |=> !cmd_w);

  a_r5_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_w && emrs_seen_q) |-> (since_q >= SW'(GAP_CYC)));

  a_r6_ready_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_w) |-> $past(banks_idle_i && cke_i));

  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (cs_n_o && !done_o && !busy_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(done_o) || cfg_err_o));
endmodule

bind ddr_mode_prog ddr_mode_prog_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .banks_idle_i (banks_idle_i),
  .cke_i        (cke_i),
  .cs_n_o       (cs_n_o),
  .ras_n_o      (ras_n_o),
  .cas_n_o      (cas_n_o),
  .we_n_o       (we_n_o),
  .ba_o         (ba_o),
  .addr_o       (addr_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/ddr_mode_prog_tb.sv
module ddr_mode_prog_tb;
  localparam int GAP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bl = 3'b001, cl = 3'b010;
  logic        bt = 1'b0, dll = 1'b0;
  logic [10:0] ext = '0;
  logic        banks_idle = 1'b1, cke = 1'b1;
  logic        cs_n, ras_n, cas_n, we_n, busy, done, cfg_err;
  logic [1:0]  ba;
  logic [10:0] addr;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ddr_mode_prog #(.ADDR_W(11), .BA_W(2), .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bl_code_i(bl), .bt_i(bt),
    .cl_code_i(cl), .dll_rst_i(dll), .ext_val_i(ext), .banks_idle_i(banks_idle),
    .cke_i(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .busy_o(busy), .done_o(done), .cfg_err_o(cfg_err)
  );

  function automatic bit bl_ok(input logic [2:0] c);
    return c == 3'b001 || c == 3'b010 || c == 3'b011;
  endfunction
  function automatic bit cl_ok(input logic [2:0] c);
    return c == 3'b010 || c == 3'b011 || c == 3'b110;
  endfunction
  function automatic logic [10:0] mrs_val(input logic [2:0] b, input logic t,
                                          input logic [2:0] c, input logic d);
    return {2'b00, d, 1'b0, c, t, b};
  endfunction
  function automatic bit gate_at(input int n, input int d_pre, input int drop_at, input int rise_at);
    return (n >= d_pre) && !(drop_at > 0 && n >= drop_at && n < rise_at);
  endfunction
  function automatic int first_cmd(input int from, input int d_pre, input int drop_at, input int rise_at);
    for (int n = from; n < 1000; n++) if (gate_at(n - 1, d_pre, drop_at, rise_at)) return n;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic run_seq(input logic [2:0] b, input logic t, input logic [2:0] c, input logic d,
                         input logic [10:0] x, input int d_pre, input int drop_at, input int rise_at,
                         input bit drop_cke, input bit restart, input bit scramble);
    bit valid;
    int e_exp, m_exp, d_exp, win;
    int e_cyc, m_cyc, d_cyc, err_cyc, ncmd, ndone, nerr;
    bit busy_bad, gate_bad, ba_bad;
    logic [10:0] addr_e, addr_m;
    bit gate_prev;
    valid = bl_ok(b) && cl_ok(c);
    e_exp = first_cmd(2, d_pre, drop_at, rise_at);
    m_exp = first_cmd(e_exp + GAP + 1, d_pre, drop_at, rise_at);
    d_exp = m_exp + GAP + 1;
    win   = valid ? d_exp + 3 : 8;
    e_cyc = -1; m_cyc = -1; d_cyc = -1; err_cyc = -1;
    ncmd = 0; ndone = 0; nerr = 0;
    busy_bad = 0; gate_bad = 0; ba_bad = 0;
    addr_e = '0; addr_m = '0;
    gate_prev = 1'b1;
    for (int n = 0; n <= win; n++) begin
      @(negedge clk);
      if (n >= 1) begin
        if (!cs_n && !ras_n && !cas_n && !we_n) begin
          ncmd++;
          if (!gate_prev) gate_bad = 1;
          if (ba == 2'd1) begin e_cyc = n; addr_e = addr; end
          else if (ba == 2'd0) begin m_cyc = n; addr_m = addr; end
          else ba_bad = 1;
        end else if (ba != 0 || addr != 0) ba_bad = 1;
        if (done) begin ndone++; d_cyc = n; end
        if (cfg_err) begin nerr++; err_cyc = n; end
        if (busy != (valid ? (n <= d_exp) : (n == 1))) busy_bad = 1;
      end
      if (n == 0) begin
        bl = b; bt = t; cl = c; dll = d; ext = x; start = 1'b1;
      end else if (n == 1) begin
        start = 1'b0;
        if (scramble) begin
          bl = 3'($urandom); bt = 1'($urandom); cl = 3'($urandom);
          dll = 1'($urandom); ext = 11'($urandom);
        end
      end else if (n == 4 && restart) begin
        start = 1'b1; bl = ~b; cl = ~c; ext = ~x;
      end else if (n == 5) begin
        start = 1'b0;
      end
      gate_prev = gate_at(n, d_pre, drop_at, rise_at);
      if (drop_cke && drop_at > 0 && n >= drop_at && n < rise_at) begin
        cke = 1'b0; banks_idle = 1'b1;
      end else begin
        cke = 1'b1; banks_idle = gate_prev;
      end
    end
    start = 1'b0; banks_idle = 1'b1; cke = 1'b1;
    chk(!busy_bad, "R10", "busy window", busy_bad, 0);
    chk(!ba_bad, "R1", "nop pins between writes", ba_bad, 0);
    if (valid) begin
      chk(e_cyc == e_exp, "R3", "extended write cycle", e_cyc, e_exp);
      chk(addr_e == (scramble ? x : x), "R2", "extended value", addr_e, x);
      chk(addr_m == mrs_val(b, t, c, d), "R4", "base write address", addr_m, mrs_val(b, t, c, d));
      chk(m_cyc == m_exp, "R5", "base write cycle", m_cyc, m_exp);
      chk(!gate_bad, "R6", "write while not ready", gate_bad, 0);
      chk(d_cyc == d_exp && ndone == 1, "R9", "done cycle", d_cyc, d_exp);
      chk(ncmd == 2, "R10", "command count", ncmd, 2);
    end else begin
      chk(err_cyc == 2 && nerr == 1, bl_ok(b) ? "R8" : "R7", "error pulse cycle", err_cyc, 2);
      chk(ncmd == 0 && ndone == 0, bl_ok(b) ? "R8" : "R7", "writes after reject", ncmd + ndone, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk(cs_n && ras_n && cas_n && we_n, "R1", "strobes in reset", {cs_n, ras_n, cas_n, we_n}, 15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cfg_err, "R1", "flags after reset", {busy, done, cfg_err}, 0);
    chk(ba == 0 && addr == 0, "R1", "address after reset", addr, 0);
    // directed
    run_seq(3'b001, 1'b0, 3'b010, 1'b0, 11'h000, 0, 0, 0, 0, 0, 0);
    run_seq(3'b011, 1'b1, 3'b110, 1'b1, 11'h5a5, 3, 0, 0, 0, 0, 0);
    run_seq(3'b010, 1'b1, 3'b011, 1'b1, 11'h7ff, 0, 3, 6, 0, 0, 0);  // banks busy in gap
    run_seq(3'b010, 1'b0, 3'b011, 1'b0, 11'h123, 2, 4, 8, 1, 0, 0);  // cke low in gap
    run_seq(3'b011, 1'b0, 3'b010, 1'b1, 11'h0f0, 0, 0, 0, 0, 1, 0);  // R10 restart ignored
    run_seq(3'b001, 1'b1, 3'b110, 1'b0, 11'h321, 0, 0, 0, 0, 0, 1);  // R2 scramble
    foreach (bl[i]) begin end
    for (int k = 0; k < 8; k++) begin
      if (!bl_ok(3'(k))) run_seq(3'(k), 1'b0, 3'b011, 1'b0, 11'h001, 0, 0, 0, 0, 0, 0);
      if (!cl_ok(3'(k))) run_seq(3'b010, 1'b0, 3'(k), 1'b0, 11'h002, 2, 0, 0, 0, 0, 0);
    end
    // random
    for (int i = 0; i < 40; i++) begin
      logic [2:0] rb, rc;
      int dp, da, ra;
      rb = ($urandom % 4 != 0) ? 3'(1 + $urandom % 3) : 3'($urandom);
      case ($urandom % 4)
        0: rc = 3'($urandom);
        1: rc = 3'b010;
        2: rc = 3'b011;
        default: rc = 3'b110;
      endcase
      dp = $urandom % 5;
      da = 0; ra = 0;
      if ($urandom % 2 == 1) begin
        da = first_cmd(2, dp, 0, 0) + 1 + $urandom % (GAP + 1);
        ra = da + 1 + $urandom % 4;
      end
      run_seq(rb, 1'($urandom), rc, 1'($urandom), 11'($urandom), dp, da, ra,
              1'($urandom), bl_ok(rb) && cl_ok(rc) && ($urandom % 4 == 0), 1'($urandom));
    end
    summary();
  end
endmodule